// File: doc/BRIEF.md
# Two-level masked interrupt combiner

This block gathers interrupt requests from three second-level groups (a USB core group, a DMA group and a GPIO group) and from direct first-level events. It keeps them in one first-level source register, masks that register, and drives a single interrupt pin. Each group, and the first level too, has a source register that hardware events can set. Software reaches it through three word-wide access slots: write-one-to-set, write-one-to-clear and mask. A set mask bit blocks its source.

Unmasked activity in a group is folded into fixed summary bits of the first-level source. The USB core group is split into halves. Its low 16 bits drive a transmit summary bit, and its high 16 bits drive a receive summary bit. The DMA group and the GPIO group each drive one summary bit. A polarity bit in a configuration register selects whether the pin is high while an unmasked request is pending or while none is pending. An enable input gates the pin in both cases. Software uses a plain word write/read port: writes take effect on a clock edge, and reads are combinational.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all source registers and the configuration register read 0, and every mask register (group and first level) reads 0xFFFFFFFF.
- R2: A write to a set slot ORs the written word into that source register. A write to a source slot changes nothing.
- R3: A write to a clear slot clears the source bits that are 1 in the written word. A hardware event on a bit in the same cycle keeps that bit set.
- R4: A hardware event bit that is high at a clock edge sets the matching bit of its source register (USB, DMA, GPIO or first level).
- R5: First-level bit 9 is 1 exactly when an unmasked bit in USB group bits 15:0 is set. First-level bit 8 is 1 exactly when an unmasked bit in USB group bits 31:16 is set.
- R6: First-level bit 24 is 1 exactly when an unmasked DMA group bit is set. First-level bit 25 is 1 exactly when an unmasked GPIO group bit is set.
- R7: Set and clear writes cannot change first-level bits 8, 9, 24 and 25; only the group state drives them.
- R8: When configuration bit 17 is 1, the pin equals the enable input ANDed with "some unmasked first-level bit is set".
- R9: When configuration bit 17 is 0, the pin equals the enable input ANDed with "no unmasked first-level bit is set".
- R10: A mask bit of 1 stops its source bit from reaching the summary bits (group masks) or the pin (first-level mask).
- R11: The word map has configuration at 0x83C. The groups are USB at 0x840, DMA at 0x850, GPIO at 0x860 and first level at 0x870, with slots at +0 source, +4 set, +8 clear and +C mask. Reads of the source, set and clear slots return the source register, and the mask slot returns the mask. Any other address reads 0.
- R12: The pin and the summary bits change as a result of a write right after the clock edge that takes the write, not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 12 | Byte address for reads and writes |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data |
| usb_evt_i | input | 32 | USB core group hardware events |
| dma_evt_i | input | 32 | DMA group hardware events |
| gpio_evt_i | input | 32 | GPIO group hardware events |
| top_evt_i | input | 32 | Direct first-level hardware events |
| irq_en_i | input | 1 | Pin enable |
| irq_o | output | 1 | Interrupt pin |

## Verification
The bench targets the USB half split. A design that tests the wrong half, or ORs both halves into one bit, shows bits 8 and 9 swapped or together. It also tries to write the summary bits through the first-level set slot; a design without the override would report a stale bit 9 after the group is cleared. A clear that arrives in the same cycle as a hardware event checks set-over-clear priority, which a swapped update order would lose. The pin is checked in both polarities with the enable low, in the cycle before and the cycle after the write edge, so an inverted polarity, a missing gate or an extra pipeline stage each show up.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // Word slots inside one group window, decoded from address bits 3:2
  typedef enum logic [1:0] {
    SLOT_SRC  = 2'd0,
    SLOT_SET  = 2'd1,
    SLOT_CLR  = 2'd2,
    SLOT_MASK = 2'd3
  } slot_e;

  // Group windows in address order
  typedef enum logic [1:0] {
    GRP_USB  = 2'd0,
    GRP_DMA  = 2'd1,
    GRP_GPIO = 2'd2,
    GRP_TOP  = 2'd3
  } grp_e;

  localparam int unsigned NUM_GRP = 4;
endpackage

// File: rtl/irq_group.sv
module irq_group #(
  parameter int unsigned       DW       = 32,
  parameter logic [DW-1:0]     RST_MASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_set_i,
  input  logic          wr_clr_i,
  input  logic          wr_mask_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] hw_set_i,
  output logic [DW-1:0] src_q,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] pend_o
);
  logic [DW-1:0] src_d, mask_d;
  logic [DW-1:0] clr_bits, set_bits;

  always_comb begin
    clr_bits = wr_clr_i ? wdata_i : '0;
    set_bits = wr_set_i ? wdata_i : '0;
    // clear first, so a same-cycle set or hardware event wins
    src_d    = (src_q & ~clr_bits) | set_bits | hw_set_i;
    mask_d   = wr_mask_i ? wdata_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      mask_q <= RST_MASK;
    end else begin
      src_q  <= src_d;
      mask_q <= mask_d;
    end
  end

  assign pend_o = src_q & ~mask_q;

  // R2
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set_i |=> ((src_q & $past(wdata_i)) == $past(wdata_i)));
  // R3
  clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr_i && !wr_set_i) |=> ((src_q & $past(wdata_i & ~hw_set_i)) == '0));
  // R4
  hw_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set_i) |=> ((src_q & $past(hw_set_i)) == $past(hw_set_i)));
  // R10
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask_i |=> (mask_q == $past(wdata_i)));
endmodule

// File: rtl/irq_fold.sv
module irq_fold #(
  parameter int unsigned DW       = 32,
  parameter int unsigned TX_BIT   = 9,
  parameter int unsigned RX_BIT   = 8,
  parameter int unsigned DMA_BIT  = 24,
  parameter int unsigned GPIO_BIT = 25
) (
  input  logic [DW-1:0] usb_pend_i,
  input  logic [DW-1:0] dma_pend_i,
  input  logic [DW-1:0] gpio_pend_i,
  input  logic [DW-1:0] top_stored_i,
  input  logic [DW-1:0] top_mask_i,
  input  logic          pol_high_i,
  input  logic          en_i,
  output logic [DW-1:0] top_eff_o,
  output logic          irq_o
);
  localparam int unsigned HALF = DW / 2;
  localparam logic [DW-1:0] SUM_MASK = (DW'(1) << TX_BIT) | (DW'(1) << RX_BIT) |
                                       (DW'(1) << DMA_BIT) | (DW'(1) << GPIO_BIT);

  logic [DW-1:0] summary;
  logic          any_pend;

  always_comb begin
    summary           = '0;
    summary[TX_BIT]   = |usb_pend_i[HALF-1:0];
    summary[RX_BIT]   = |usb_pend_i[DW-1:HALF];
    summary[DMA_BIT]  = |dma_pend_i;
    summary[GPIO_BIT] = |gpio_pend_i;
    top_eff_o         = (top_stored_i & ~SUM_MASK) | summary;
    any_pend          = |(top_eff_o & ~top_mask_i);
    irq_o             = en_i & (pol_high_i ? any_pend : ~any_pend);
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int unsigned   DW       = 32,
  parameter int unsigned   AW       = 12,
  parameter logic [AW-1:0] CFG_ADDR = 12'h83C,
  parameter logic [AW-1:0] GRP_BASE = 12'h840,
  parameter int unsigned   POL_BIT  = 17,
  parameter int unsigned   TX_BIT   = 9,
  parameter int unsigned   RX_BIT   = 8,
  parameter int unsigned   DMA_BIT  = 24,
  parameter int unsigned   GPIO_BIT = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr_i,
  input  logic          reg_wr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic [DW-1:0] usb_evt_i,
  input  logic [DW-1:0] dma_evt_i,
  input  logic [DW-1:0] gpio_evt_i,
  input  logic [DW-1:0] top_evt_i,
  input  logic          irq_en_i,
  output logic          irq_o
);
  import irq_agg_pkg::*;

  localparam int unsigned   RW       = AW - 4;
  localparam logic [RW-1:0] BASE_ROW = GRP_BASE[AW-1:4];

  slot_e         slot;
  logic          cfg_hit;
  logic [NUM_GRP-1:0] grp_hit;
  logic [DW-1:0] grp_evt  [NUM_GRP];
  logic [DW-1:0] grp_src  [NUM_GRP];
  logic [DW-1:0] grp_mask [NUM_GRP];
  logic [DW-1:0] grp_pend [NUM_GRP];
  logic [DW-1:0] grp_view [NUM_GRP];
  logic [DW-1:0] top_eff;
  logic [DW-1:0] cfg_q, cfg_d;

  assign slot    = slot_e'(reg_addr_i[3:2]);
  assign cfg_hit = (reg_addr_i[AW-1:2] == CFG_ADDR[AW-1:2]);

  assign grp_evt[GRP_USB]  = usb_evt_i;
  assign grp_evt[GRP_DMA]  = dma_evt_i;
  assign grp_evt[GRP_GPIO] = gpio_evt_i;
  assign grp_evt[GRP_TOP]  = top_evt_i;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_hit[g] = (reg_addr_i[AW-1:4] == BASE_ROW + RW'(g));

    irq_group #(.DW(DW), .RST_MASK('1)) u_grp (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_set_i  (reg_wr_i && grp_hit[g] && slot == SLOT_SET),
      .wr_clr_i  (reg_wr_i && grp_hit[g] && slot == SLOT_CLR),
      .wr_mask_i (reg_wr_i && grp_hit[g] && slot == SLOT_MASK),
      .wdata_i   (reg_wdata_i),
      .hw_set_i  (grp_evt[g]),
      .src_q     (grp_src[g]),
      .mask_q    (grp_mask[g]),
      .pend_o    (grp_pend[g])
    );

    if (g == int'(GRP_TOP)) begin : g_view_top
      assign grp_view[g] = top_eff;
    end else begin : g_view_sub
      assign grp_view[g] = grp_src[g];
    end
  end

  irq_fold #(
    .DW(DW), .TX_BIT(TX_BIT), .RX_BIT(RX_BIT),
    .DMA_BIT(DMA_BIT), .GPIO_BIT(GPIO_BIT)
  ) u_fold (
    .usb_pend_i   (grp_pend[GRP_USB]),
    .dma_pend_i   (grp_pend[GRP_DMA]),
    .gpio_pend_i  (grp_pend[GRP_GPIO]),
    .top_stored_i (grp_src[GRP_TOP]),
    .top_mask_i   (grp_mask[GRP_TOP]),
    .pol_high_i   (cfg_q[POL_BIT]),
    .en_i         (irq_en_i),
    .top_eff_o    (top_eff),
    .irq_o        (irq_o)
  );

  // configuration register: next state and storage
  always_comb begin
    cfg_d = (reg_wr_i && cfg_hit) ? reg_wdata_i : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    if (cfg_hit) reg_rdata_o = cfg_q;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (grp_hit[g]) reg_rdata_o = (slot == SLOT_MASK) ? grp_mask[g] : grp_view[g];
    end
  end

  // R8
  pin_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> !irq_o);
  // R7
  summary_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && grp_hit[GRP_TOP] && slot == SLOT_SET &&
     $stable(grp_pend[GRP_DMA]) && grp_pend[GRP_DMA] == '0) |=> !top_eff[DMA_BIT]);
endmodule

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;
  localparam int PERIOD = 10;
  localparam logic [31:0] SUMS = 32'h0300_0300;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] reg_addr = 0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [31:0] usb_evt = 0, dma_evt = 0, gpio_evt = 0, top_evt = 0;
  logic        irq_en = 1;
  logic        irq;

  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  irq_aggregator dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .usb_evt_i(usb_evt),
    .dma_evt_i(dma_evt), .gpio_evt_i(gpio_evt), .top_evt_i(top_evt),
    .irq_en_i(irq_en), .irq_o(irq)
  );

  // behavioural reference model
  logic [31:0] m_src [4];
  logic [31:0] m_msk [4];
  logic [31:0] m_cfg;

  function automatic logic [31:0] m_top();
    logic [31:0] u, t;
    u = m_src[0] & ~m_msk[0];
    t = m_src[3] & ~SUMS;
    if (u[15:0] != 0)  t[9] = 1;
    if (u[31:16] != 0) t[8] = 1;
    if ((m_src[1] & ~m_msk[1]) != 0) t[24] = 1;
    if ((m_src[2] & ~m_msk[2]) != 0) t[25] = 1;
    return t;
  endfunction

  function automatic logic m_pin();
    logic p;
    p = (m_top() & ~m_msk[3]) != 0;
    if (!irq_en) return 0;
    return m_cfg[17] ? p : !p;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    int off, g, s;
    if (a == 12'h83C) return m_cfg;
    if (a < 12'h840 || a >= 12'h880) return 0;
    off = int'(a) - 'h840;
    g = off / 16;
    s = (off % 16) / 4;
    if (s == 3) return m_msk[g];
    return (g == 3) ? m_top() : m_src[g];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < 4; g++) begin m_src[g] = 0; m_msk[g] = '1; end
      m_cfg = 0;
    end else begin
      logic [31:0] ev [4];
      ev[0] = usb_evt; ev[1] = dma_evt; ev[2] = gpio_evt; ev[3] = top_evt;
      for (int g = 0; g < 4; g++) begin
        logic [11:0] b;
        b = 12'h840 + 12'(g * 16);
        if (reg_wr && reg_addr == b + 12'h8) m_src[g] = m_src[g] & ~reg_wdata;
        if (reg_wr && reg_addr == b + 12'h4) m_src[g] = m_src[g] | reg_wdata;
        if (reg_wr && reg_addr == b + 12'hC) m_msk[g] = reg_wdata;
        m_src[g] = m_src[g] | ev[g];
      end
      if (reg_wr && reg_addr == 12'h83C) m_cfg = reg_wdata;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (irq !== m_pin()) begin
        errors++;
        $display("FAIL R8 R9 cycle pin: actual %0b expected %0b", irq, m_pin());
      end
      checks++;
      if (reg_rdata !== m_read(reg_addr)) begin
        errors++;
        $display("FAIL R11 cycle read @%h: actual %h expected %h", reg_addr, reg_rdata, m_read(reg_addr));
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    tick();
    reg_wr = 0;
  endtask

  task automatic chk_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a; #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s read @%h: actual %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic chk_pin(input logic exp, input string tag);
    #1;
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s pin: actual %0b expected %0b", tag, irq, exp);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk_rd(12'h87C, 32'hFFFF_FFFF, "R1");
    chk_rd(12'h84C, 32'hFFFF_FFFF, "R1");
    chk_rd(12'h870, 32'h0, "R1");
    chk_rd(12'h83C, 32'h0, "R1");
    chk_pin(1'b1, "R1 R9");

    // R2 set, R10 group mask blocks summary
    wr(12'h844, 32'h1);
    chk_rd(12'h840, 32'h1, "R2");
    chk_rd(12'h870, 32'h0, "R10");
    wr(12'h84C, 32'h0);
    chk_rd(12'h870, 32'h200, "R5 tx");
    chk_pin(1'b1, "R10 top mask");
    wr(12'h87C, 32'hFFFF_FDFF);
    chk_pin(1'b0, "R9");

    // R12 timing of polarity change
    reg_addr = 12'h83C; reg_wdata = 32'h0002_0000; reg_wr = 1;
    chk_pin(1'b0, "R12 before edge");
    tick(); reg_wr = 0;
    chk_pin(1'b1, "R12 R8 after edge");
    irq_en = 0; chk_pin(1'b0, "R8 enable low");
    irq_en = 1; chk_pin(1'b1, "R8 enable high");

    // R5 high half, R3 clear
    wr(12'h844, 32'h0001_0000);
    chk_rd(12'h870, 32'h300, "R5 rx");
    wr(12'h848, 32'h1);
    chk_rd(12'h870, 32'h100, "R3 R5");
    chk_rd(12'h840, 32'h0001_0000, "R3");
    chk_pin(1'b0, "R10 rx masked at top");
    wr(12'h87C, 32'h0);
    chk_pin(1'b1, "R8");
    wr(12'h848, 32'hFFFF_FFFF);
    chk_rd(12'h870, 32'h0, "R3");
    chk_pin(1'b0, "R8 none pending");

    // R6 DMA and GPIO summaries
    wr(12'h854, 32'h4);
    chk_rd(12'h850, 32'h4, "R6");
    chk_rd(12'h870, 32'h0, "R6 R10 masked");
    wr(12'h85C, 32'h0);
    chk_rd(12'h870, 32'h0100_0000, "R6 dma");
    chk_pin(1'b1, "R6 R8");
    wr(12'h858, 32'h4);
    chk_rd(12'h870, 32'h0, "R6 dma cleared");
    wr(12'h864, 32'h80);
    wr(12'h86C, 32'h0);
    chk_rd(12'h870, 32'h0200_0000, "R6 gpio");
    wr(12'h868, 32'h80);
    chk_rd(12'h870, 32'h0, "R6 gpio cleared");

    // R7 summary bits locked, R2 source slot read-only, R11 slot aliases
    wr(12'h874, SUMS);
    chk_rd(12'h870, 32'h0, "R7");
    chk_pin(1'b0, "R7");
    wr(12'h874, 32'h1);
    chk_rd(12'h870, 32'h1, "R2 top set");
    chk_rd(12'h874, 32'h1, "R11 set alias");
    chk_rd(12'h878, 32'h1, "R11 clear alias");
    wr(12'h870, 32'hF0);
    chk_rd(12'h870, 32'h1, "R2 source slot ignored");
    wr(12'h878, 32'h1);
    chk_rd(12'h870, 32'h0, "R3 top clear");

    // R4 hardware events
    top_evt = 32'h8; tick(); top_evt = 0;
    chk_rd(12'h870, 32'h8, "R4 top");
    usb_evt = 32'h2; tick(); usb_evt = 0;
    chk_rd(12'h840, 32'h2, "R4 usb");
    chk_rd(12'h870, 32'h208, "R4 R5");

    // R3 clear versus same-cycle event
    top_evt = 32'h8;
    wr(12'h878, 32'h8);
    top_evt = 0;
    chk_rd(12'h870, 32'h208, "R3 event wins");

    // R9 active-low with pending
    wr(12'h83C, 32'h0);
    chk_pin(1'b0, "R9 pending");
    chk_rd(12'h900, 32'h0, "R11 unmapped");
    chk_rd(12'h83C, 32'h0, "R11 config");

    tick(); tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule